// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Checker

This block sits beside a single data rate SDRAM controller and watches the command pins it drives: clock enable, chip select, the three strobes, the bank select and the multiplexed address. Each sampled clock is decoded into a command. The checker keeps its own view of which banks hold an open row, how many clocks have passed since each bank was opened or closed, and whether an auto-precharge burst is still running. Any command that breaks the multi-bank sequencing or timing rules sets a sticky error.

The minimum spacings for open-to-access, close-to-open, open-to-close and open-to-open on another bank are supplied as clock counts on configuration inputs. This lets one netlist follow any clock rate. Burst length and CAS latency are taken from the address bits of every mode-register write, so the checker can tell where an auto-precharge burst ends. The error output names the first rule broken and the bank involved. It holds that value until a synchronous clear.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A clock with `cke_i` low or `cs_ni` high carries no command. It sets no error and changes no bank state. With `cs_ni` low, {ras,cas,we} decodes as 111 NOP, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode write and 110 burst stop.
- R2: A refresh or mode write while any bank is open gives code 3. The reported bank is the lowest-numbered open bank.
- R3: Any command other than NOP in the MRD-1 clocks after a mode write gives code 1. With the default MRD of 2, this is the very next clock.
- R4: A read or write fewer than `t_rcd_i` clocks after the activate of that bank gives code 6.
- R5: An activate fewer than `t_rp_i` clocks after that bank was precharged gives code 7.
- R6: A precharge of an open bank fewer than `t_ras_i` clocks after its activate gives code 8. For a precharge of all banks, the lowest offending bank is reported.
- R7: An activate fewer than `t_rrd_i` clocks after an activate of a different bank gives code 9.
- R8: A read or write with address bit 10 high starts an auto-precharge burst. The burst lasts BL-1 clocks after a write and CL+BL-1 clocks after a read. Any read or write inside that window gives code 2. The bank closes on the last clock of the burst, and R5 then counts from that clock.
- R9: A precharge with address bit 10 high closes every bank. Otherwise only the bank on `ba_i` closes. A later read of a closed bank gives code 4.
- R10: A read or write to a closed bank gives code 4. An activate of an open bank gives code 5.
- R11: Each mode write loads the burst length code from address bits 2:0 (0,1,2,3 give 1,2,4,8, anything else 8) and the CAS latency from bits 6:4. After reset the values are BL 1 and CL 3.
- R12: When one command breaks several rules, the lowest code wins. The first error is held, code and bank unchanged, until `clr_i`. `clr_i` clears the error in the next clock and takes precedence over a new error in the same clock.
- R13: After reset `err_o` is 0, all banks are closed and no timing window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the held error |
| cke_i | input | 1 | Observed clock enable |
| cs_ni | input | 1 | Observed chip select, active low |
| ras_ni | input | 1 | Observed row strobe, active low |
| cas_ni | input | 1 | Observed column strobe, active low |
| we_ni | input | 1 | Observed write enable, active low |
| ba_i | input | BA_W | Observed bank select |
| addr_i | input | ADDR_W | Observed address bus |
| t_rcd_i | input | TW | Activate to read/write, clocks |
| t_rp_i | input | TW | Precharge to activate, clocks |
| t_ras_i | input | TW | Activate to precharge, clocks |
| t_rrd_i | input | TW | Activate to activate on another bank, clocks |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 4 | Code of the first broken rule |
| err_bank_o | output | BA_W | Bank of the first broken rule |

## Verification
The hardest case to reach is the end of an auto-precharge burst. The length of that window depends on burst length and CAS latency loaded by an earlier mode write. The bank then closes on its own, with no precharge on the bus. The stimulus programs a burst length of four, opens a bank, writes with auto-precharge, and then reads an idle bank inside the window. This read must report the lockout code, which outranks the idle-bank code. The bench then clears the error and activates the same bank one clock after the burst ends, which must report the precharge-time code. A behavioural reference model built on cycle stamps is compared with all outputs on every clock.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [3:0] {
    CMD_NONE, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  // numeric order is the reporting priority (lowest wins)
  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRD      = 4'd1,
    ERR_AP_BUSY  = 4'd2,
    ERR_NOT_IDLE = 4'd3,
    ERR_RW_IDLE  = 4'd4,
    ERR_ACT_OPEN = 4'd5,
    ERR_TRCD     = 4'd6,
    ERR_TRP      = 4'd7,
    ERR_TRAS     = 4'd8,
    ERR_TRRD     = 4'd9
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_i || cs_ni) cmd_o = CMD_NONE;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          pre_i,
  output logic          active_o,
  output logic [TW-1:0] act_cnt_o,
  output logic [TW-1:0] pre_cnt_o
);
  localparam logic [TW-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      act_cnt_o <= SAT;
      pre_cnt_o <= SAT;
    end else begin
      if (act_i)      active_o <= 1'b1;
      else if (pre_i) active_o <= 1'b0;
      if (act_i)                 act_cnt_o <= TW'(1);
      else if (act_cnt_o != SAT) act_cnt_o <= act_cnt_o + 1'b1;
      if (pre_i)                 pre_cnt_o <= TW'(1);
      else if (pre_cnt_o != SAT) pre_cnt_o <= pre_cnt_o + 1'b1;
    end
  end

  p_pre_closes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i && !act_i |=> !active_o);
  p_act_opens_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> active_o && act_cnt_o == TW'(1));
endmodule

// File: rtl/sdram_ap_track.sv
module sdram_ap_track #(
  parameter int BA_W  = 2,
  parameter int LEN_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mrs_i,
  input  logic [2:0]      bl_code_i,
  input  logic [2:0]      cl_i,
  input  logic            rw_i,
  input  logic            rd_i,
  input  logic            ap_i,
  input  logic [BA_W-1:0] ba_i,
  output logic            busy_o,
  output logic            end_o,
  output logic [BA_W-1:0] end_bank_o
);
  logic [2:0]       bl_code_q, cl_q;
  logic [LEN_W-1:0] left_q, bl_len, load;
  logic [BA_W-1:0]  bank_q;
  logic             start;

  always_comb begin
    unique case (bl_code_q)
      3'd0:    bl_len = LEN_W'(1);
      3'd1:    bl_len = LEN_W'(2);
      3'd2:    bl_len = LEN_W'(4);
      default: bl_len = LEN_W'(8);
    endcase
    load = bl_len + (rd_i ? LEN_W'(cl_q) : '0) - LEN_W'(1);
  end

  assign start      = rw_i && ap_i;
  assign busy_o     = left_q != '0;
  assign end_o      = (left_q == LEN_W'(1)) || (start && load == '0);
  assign end_bank_o = (left_q == LEN_W'(1)) ? bank_q : ba_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_code_q <= 3'd0;
      cl_q      <= 3'd3;
      left_q    <= '0;
      bank_q    <= '0;
    end else begin
      if (mrs_i) begin
        bl_code_q <= bl_code_i;
        cl_q      <= cl_i;
      end
      if (start) begin
        left_q <= load;
        bank_q <= ba_i;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  p_mode_capture_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_i |=> cl_q == $past(cl_i) && bl_code_q == $past(bl_code_i));
  p_lock_opens_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && load != '0 |=> busy_o);
  p_lock_drains_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start |=> left_q == $past(left_q) - LEN_W'(1));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int TW     = 5,
  parameter int MRD    = 2,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TW-1:0]     t_rcd_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_ras_i,
  input  logic [TW-1:0]     t_rrd_i,
  output logic              err_o,
  output logic [3:0]        err_code_o,
  output logic [BA_W-1:0]   err_bank_o
);
  localparam int MRD_W = $clog2(MRD + 1);
  localparam int LEN_W = 5;
  localparam logic [TW-1:0] SAT = '1;

  cmd_e cmd;
  logic is_rw, ap, ap_busy, ap_end;
  logic [BA_W-1:0] ap_end_bank;
  logic [NBANK-1:0] active, act_hit, pre_hit, tras_bad;
  logic [TW-1:0] act_cnt [NBANK];
  logic [TW-1:0] pre_cnt [NBANK];
  logic [TW-1:0] rrd_q;
  logic [BA_W-1:0] last_act_q, low_act, low_tras;
  logic [MRD_W-1:0] mrd_q;
  err_e viol;
  logic [BA_W-1:0] viol_bank;
  logic unused_addr;

  assign unused_addr = ^addr_i;
  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign ap    = addr_i[AP_BIT];

  sdram_cmd_decode u_dec (
    .cke_i, .cs_ni, .ras_ni, .cas_ni, .we_ni, .cmd_o(cmd)
  );

  sdram_ap_track #(.BA_W(BA_W), .LEN_W(LEN_W)) u_ap (
    .clk_i, .rst_ni,
    .mrs_i(cmd == CMD_MRS), .bl_code_i(addr_i[2:0]), .cl_i(addr_i[6:4]),
    .rw_i(is_rw), .rd_i(cmd == CMD_RD), .ap_i(ap), .ba_i,
    .busy_o(ap_busy), .end_o(ap_end), .end_bank_o(ap_end_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_hit[b] = (cmd == CMD_ACT) && (ba_i == BA_W'(b));
    assign pre_hit[b] = ((cmd == CMD_PRE) && (ap || ba_i == BA_W'(b))) ||
                        (ap_end && ap_end_bank == BA_W'(b));
    assign tras_bad[b] = active[b] && (act_cnt[b] < t_ras_i);
    sdram_bank_track #(.TW(TW)) u_bank (
      .clk_i, .rst_ni, .act_i(act_hit[b]), .pre_i(pre_hit[b]),
      .active_o(active[b]), .act_cnt_o(act_cnt[b]), .pre_cnt_o(pre_cnt[b])
    );
  end

  always_comb begin
    low_act  = '0;
    low_tras = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (active[b])   low_act  = BA_W'(b);
      if (tras_bad[b]) low_tras = BA_W'(b);
    end
  end

  always_comb begin
    viol      = ERR_NONE;
    viol_bank = ba_i;
    if (mrd_q != '0 && cmd != CMD_NONE && cmd != CMD_NOP)
      viol = ERR_MRD;
    else if (is_rw && ap_busy)
      viol = ERR_AP_BUSY;
    else if ((cmd == CMD_MRS || cmd == CMD_REF) && |active) begin
      viol      = ERR_NOT_IDLE;
      viol_bank = low_act;
    end else if (is_rw && !active[ba_i])
      viol = ERR_RW_IDLE;
    else if (cmd == CMD_ACT && active[ba_i])
      viol = ERR_ACT_OPEN;
    else if (is_rw && act_cnt[ba_i] < t_rcd_i)
      viol = ERR_TRCD;
    else if (cmd == CMD_ACT && pre_cnt[ba_i] < t_rp_i)
      viol = ERR_TRP;
    else if (cmd == CMD_PRE && ap && |tras_bad) begin
      viol      = ERR_TRAS;
      viol_bank = low_tras;
    end else if (cmd == CMD_PRE && !ap && tras_bad[ba_i])
      viol = ERR_TRAS;
    else if (cmd == CMD_ACT && rrd_q < t_rrd_i && ba_i != last_act_q)
      viol = ERR_TRRD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q      <= SAT;
      last_act_q <= '0;
      mrd_q      <= '0;
    end else begin
      if (cmd == CMD_ACT) begin
        rrd_q      <= TW'(1);
        last_act_q <= ba_i;
      end else if (rrd_q != SAT) begin
        rrd_q <= rrd_q + 1'b1;
      end
      if (cmd == CMD_MRS)  mrd_q <= MRD_W'(MRD - 1);
      else if (mrd_q != '0) mrd_q <= mrd_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      err_bank_o <= '0;
    end else if (clr_i) begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      err_bank_o <= '0;
    end else if (!err_o && viol != ERR_NONE) begin
      err_o      <= 1'b1;
      err_code_o <= viol;
      err_bank_o <= viol_bank;
    end
  end

  p_no_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_NONE && !ap_end |=> active == $past(active));
  p_busy_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS || cmd == CMD_REF) && |active && !clr_i |=> err_o);
  p_mrd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_q != '0 && cmd != CMD_NONE && cmd != CMD_NOP && !clr_i |=> err_o);
  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o && $stable(err_code_o) && $stable(err_bank_o));
  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o && err_code_o == 4'd0);
endmodule

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
  localparam int MRD = 2;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RRD = 2;

  logic clk = 0, rst_n = 0, clr = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [12:0] addr = 0;
  logic err;
  logic [3:0] code;
  logic [1:0] bank;

  int checks = 0, errors = 0;
  string cur_req = "R13";

  always #2 clk = ~clk;

  sdram_cmd_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr),
    .t_rcd_i(5'(T_RCD)), .t_rp_i(5'(T_RP)), .t_ras_i(5'(T_RAS)), .t_rrd_i(5'(T_RRD)),
    .err_o(err), .err_code_o(code), .err_bank_o(bank)
  );

  // ---------------- reference model (cycle stamps) ----------------
  int cyc, mrs_last, rrd_last, rrd_bank, ap_start, ap_end, ap_bank, bl_m, cl_m;
  int last_act [4];
  int last_pre [4];
  bit open_m [4];
  bit e_err;
  int e_code, e_bank;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; mrs_last = -1000; rrd_last = -1000; rrd_bank = 0;
      ap_start = -1000; ap_end = -1000; ap_bank = 0; bl_m = 1; cl_m = 3;
      for (int b = 0; b < 4; b++) begin
        last_act[b] = -1000; last_pre[b] = -1000; open_m[b] = 0;
      end
      e_err = 0; e_code = 0; e_bank = 0;
    end else begin
      string c;
      int v, vb, b0, load;
      bit any, a10;
      cyc++;
      a10 = addr[10];
      b0 = int'(ba);
      if (!cke || cs_n) c = "none";
      else case ({ras_n, cas_n, we_n})
        3'b111: c = "nop";  3'b011: c = "act"; 3'b101: c = "rd";
        3'b100: c = "wr";   3'b010: c = "pre"; 3'b001: c = "ref";
        3'b000: c = "mrs";  default: c = "bst";
      endcase
      any = open_m[0] | open_m[1] | open_m[2] | open_m[3];
      v = 0; vb = b0;
      if (c != "none" && c != "nop" && cyc - mrs_last < MRD) v = 1;
      else if ((c == "rd" || c == "wr") && cyc > ap_start && cyc <= ap_end) v = 2;
      else if ((c == "mrs" || c == "ref") && any) begin
        v = 3;
        for (int b = 3; b >= 0; b--) if (open_m[b]) vb = b;
      end
      else if ((c == "rd" || c == "wr") && !open_m[b0]) v = 4;
      else if (c == "act" && open_m[b0]) v = 5;
      else if ((c == "rd" || c == "wr") && cyc - last_act[b0] < T_RCD) v = 6;
      else if (c == "act" && cyc - last_pre[b0] < T_RP) v = 7;
      else if (c == "pre" && a10) begin
        for (int b = 3; b >= 0; b--)
          if (open_m[b] && cyc - last_act[b] < T_RAS) begin v = 8; vb = b; end
      end
      else if (c == "pre" && open_m[b0] && cyc - last_act[b0] < T_RAS) v = 8;
      if (v == 0 && c == "act" && cyc - rrd_last < T_RRD && b0 != rrd_bank) v = 9;

      if (clr) begin e_err = 0; e_code = 0; e_bank = 0; end
      else if (!e_err && v != 0) begin e_err = 1; e_code = v; e_bank = vb; end

      if (c == "act") begin
        open_m[b0] = 1; last_act[b0] = cyc; rrd_last = cyc; rrd_bank = b0;
      end else if (c == "pre") begin
        for (int b = 0; b < 4; b++)
          if (a10 || b == b0) begin open_m[b] = 0; last_pre[b] = cyc; end
      end else if (c == "mrs") begin
        bl_m = (addr[2:0] < 4) ? (1 << addr[2:0]) : 8;
        cl_m = int'(addr[6:4]);
        mrs_last = cyc;
      end else if ((c == "rd" || c == "wr") && a10) begin
        load = bl_m + ((c == "rd") ? cl_m : 0) - 1;
        ap_start = cyc; ap_end = cyc + load; ap_bank = b0;
      end
      if (cyc == ap_end) begin open_m[ap_bank] = 0; last_pre[ap_bank] = cyc; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (err !== e_err || code !== 4'(e_code) || (e_err && bank !== 2'(e_bank))) begin
        errors++;
        $display("FAIL %s model: got err=%0d code=%0d bank=%0d exp err=%0d code=%0d bank=%0d",
                 cur_req, err, code, bank, e_err, e_code, e_bank);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input bit k, input bit s, input bit r, input bit ca, input bit w,
                     input int b, input int a, input bit cl);
    @(negedge clk);
    cke = k; cs_n = s; ras_n = r; cas_n = ca; we_n = w;
    ba = 2'(b); addr = 13'(a); clr = cl;
  endtask
  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drv(1, 0, 1, 1, 1, 0, 0, 0);
  endtask
  task automatic nop_clr(); drv(1, 0, 1, 1, 1, 0, 0, 1); endtask
  task automatic act(input int b);  drv(1, 0, 0, 1, 1, b, 0, 0); endtask
  task automatic rd(input int b, input bit ap);  drv(1, 0, 1, 0, 1, b, ap ? 13'h400 : 0, 0); endtask
  task automatic wr(input int b, input bit ap);  drv(1, 0, 1, 0, 0, b, ap ? 13'h400 : 0, 0); endtask
  task automatic pre(input int b, input bit all); drv(1, 0, 0, 1, 0, b, all ? 13'h400 : 0, 0); endtask
  task automatic mrs(input int a); drv(1, 0, 0, 0, 0, 0, a, 0); endtask
  task automatic ref_cmd(); drv(1, 0, 0, 0, 1, 0, 0, 0); endtask

  task automatic chk(input string req, input bit xe, input int xc, input int xb);
    checks++;
    if (err !== xe || code !== 4'(xc) || (xe && bank !== 2'(xb))) begin
      errors++;
      $display("FAIL %s: got err=%0d code=%0d bank=%0d exp err=%0d code=%0d bank=%0d",
               req, err, code, bank, xe, xc, xb);
    end
  endtask

  task automatic cleanup();
    nop(10); pre(0, 1); nop(4); nop_clr(); nop(1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    nop(1);
    chk("R13 reset", 0, 0, 0);

    cur_req = "R11"; mrs(13'h021); nop(2);
    chk("R11 mode write legal", 0, 0, 0);

    cur_req = "R3"; mrs(13'h021); act(2); nop(1);
    chk("R3 command after mode write", 1, 1, 2);
    cleanup();

    cur_req = "R10"; rd(1, 0); nop(1);
    chk("R10 read idle bank", 1, 4, 1);
    cleanup();

    cur_req = "R4"; act(0); nop(1); rd(0, 0); nop(1);
    chk("R4 tRCD short", 1, 6, 0);
    cleanup();
    act(0); nop(2); rd(0, 0); nop(1);
    chk("R4 tRCD met", 0, 0, 0);
    cleanup();

    cur_req = "R10"; act(3); nop(3); act(3); nop(1);
    chk("R10 activate open bank", 1, 5, 3);
    cleanup();

    cur_req = "R6"; act(1); nop(2); pre(1, 0); nop(1);
    chk("R6 tRAS short", 1, 8, 1);
    cleanup();

    cur_req = "R5"; act(1); nop(6); pre(1, 0); nop(1); act(1); nop(1);
    chk("R5 tRP short", 1, 7, 1);
    cleanup();

    cur_req = "R7"; act(0); act(1); nop(1);
    chk("R7 tRRD short", 1, 9, 1);
    cleanup();

    cur_req = "R2"; act(2); nop(3); ref_cmd(); nop(1);
    chk("R2 refresh with open bank", 1, 3, 2);
    cleanup();

    cur_req = "R9"; act(0); nop(1); act(2); nop(8); pre(0, 0); nop(1); rd(2, 0); nop(1);
    chk("R9 single precharge keeps other bank", 0, 0, 0);
    rd(0, 0); nop(1);
    chk("R9 single precharge closed bank", 1, 4, 0);
    nop_clr(); nop(8); pre(0, 1); nop(1); rd(2, 0); nop(1);
    chk("R9 precharge all closes bank", 1, 4, 2);
    cleanup();

    cur_req = "R8"; mrs(13'h022); nop(2); act(1); nop(3);
    wr(1, 1); rd(3, 0); nop_clr();
    chk("R8 R11 auto-precharge lockout", 1, 2, 3);
    nop(1); act(1); nop(1);
    chk("R8 tRP from burst end", 1, 7, 1);
    cleanup();

    cur_req = "R12"; rd(1, 0); act(3); act(3); nop(1);
    chk("R12 first error held", 1, 4, 1);
    nop_clr(); nop(1);
    chk("R12 clear", 0, 0, 0);
    cleanup();

    cur_req = "R1"; mrs(13'h020);
    drv(1, 1, 0, 0, 0, 0, 0, 0);       // deselect during mode gap
    drv(0, 0, 0, 1, 1, 0, 0, 0);       // activate with cke low
    nop(1);
    chk("R1 deselect and cke low ignored", 0, 0, 0);
    rd(0, 0); nop(1);
    chk("R1 bank not opened by ignored activate", 1, 4, 0);
    cleanup();

    nop(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule